// File: doc/BRIEF.md
# Free-Running Match Timer

This block is an operating-system tick source built around one wrapping up-counter and four equality comparators. Each comparator watches the counter. When the counter reaches a channel's programmed value, that channel latches a sticky event flag. The flag drives a level interrupt for as long as the channel's enable bit is set. Software programs the block through a small word-indexed register bus. It can reload the counter at any time, retarget any match value while counting continues, clear event flags by writing ones, and mask channels individually.

The counter advances only in cycles where the count-enable input is high. The prescaler that paces that input sits outside this block, as does the interrupt controller that collects the four interrupt lines. A typical periodic tick works like this: software services a channel by clearing its flag and moving its match value forward by one period. It decides whether a target is already behind the counter from the signed difference of the two wrapped values.

Register indices on `busAddr` (byte offset = 4 x index): 0 to 3 hold the channel match values, 4 holds the counter, 5 holds the event flags and 7 holds the interrupt enables. Index 6 is unused.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the counter reads 0, the event flags (index 5) and enables (index 7) read 0, every match register (indices 0 to 3) reads all ones, and `irq` is 0.
- R2: In a cycle with `cntEn` high and no counter write, the counter advances by exactly one. With `cntEn` low it holds its value.
- R3: The counter wraps from all ones to zero and keeps counting. A match value of zero is reached through that wrap.
- R4: A bus write to index 4 loads the counter with the write data in that cycle, taking priority over the increment. Counting resumes from the loaded value.
- R5: In a cycle where `cntEn` is high and the counter equals match register n, event flag n (bit n of index 5) is set from the next cycle on. It stays set until software clears it.
- R6: Writing index 5 clears each event flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. Writing 0x0F clears all four.
- R7: When a match event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: `irq[n]` is high exactly when event flag n and enable bit n (bit n of index 7) are both 1. Writing 0 to index 7 masks every interrupt without changing the flags.
- R9: Rewriting a match register while the counter runs raises no event for a value the counter has already passed. The new value fires on its next equality.
- R10: Index 6 reads as 0, and writes to it change no register.
- R11: Reads are combinational: `busRdData` shows the register selected by `busAddr` in the same cycle. Event flags and enables appear in the low bits, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable from an external prescaler |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the selected index |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit counter and four channels. At that width, walking the counter to its wrap point is out of reach, so the bench loads the counter just below all ones and steps it across zero, with a channel targeting zero. Because `cntEn` is driven one pulse at a time, every compare happens at a known counter value. This brings the same-cycle collisions within reach: set against clear, and load against increment.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int CH_MAX = 4;
  localparam int IDX_W  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_CNT,
    SEL_STS,
    SEL_EN
  } regSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic              cntLoad;
    logic [CH_MAX-1:0] matchLoad;
    logic              stsWrite;
    logic              enWrite;
    regSel_e           rdSel;
    logic [IDX_W-1:0]  rdIdx;
  } strobe_t;
endpackage

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 3
) (
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  output strobe_t       stb
);
  localparam logic [AW-1:0] IDX_CNT = AW'(4);
  localparam logic [AW-1:0] IDX_STS = AW'(5);
  localparam logic [AW-1:0] IDX_EN  = AW'(7);
  localparam logic [AW-1:0] CH_LIM  = AW'(NUM_CH);

  always_comb begin
    stb = '0;
    if (busAddr < CH_LIM) begin
      stb.rdSel = SEL_MATCH;
      stb.rdIdx = busAddr[IDX_W-1:0];
      stb.matchLoad[busAddr[IDX_W-1:0]] = busWrEn;
    end else if (busAddr == IDX_CNT) begin
      stb.rdSel   = SEL_CNT;
      stb.cntLoad = busWrEn;
    end else if (busAddr == IDX_STS) begin
      stb.rdSel    = SEL_STS;
      stb.stsWrite = busWrEn;
    end else if (busAddr == IDX_EN) begin
      stb.rdSel   = SEL_EN;
      stb.enWrite = busWrEn;
    end
  end
endmodule

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  strobe_t           stb,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);
  localparam int PAD_W = CNT_W - NUM_CH;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  matchReg [NUM_CH];
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] enable;
  logic [NUM_CH-1:0] hitVec;
  logic [NUM_CH-1:0] clrMask;

  // free-running counter, load wins over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (stb.cntLoad) cnt <= wrData;
    else if (cntEn)       cnt <= cnt + 1'b1;
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  matchReg[ch] <= '1;
        else if (stb.matchLoad[ch]) matchReg[ch] <= wrData;
      end
      assign hitVec[ch] = cntEn && (cnt == matchReg[ch]);
    end
  endgenerate

  assign clrMask = stb.stsWrite ? wrData[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clrMask) | hitVec;
      if (stb.enWrite) enable <= wrData[NUM_CH-1:0];
    end
  end

  assign irq = status & enable;

  always_comb begin
    unique case (stb.rdSel)
      SEL_MATCH: rdData = matchReg[stb.rdIdx];
      SEL_CNT:   rdData = cnt;
      SEL_STS:   rdData = {{PAD_W{1'b0}}, status};
      SEL_EN:    rdData = {{PAD_W{1'b0}}, enable};
      default:   rdData = '0;
    endcase
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !stb.cntLoad) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !stb.cntLoad) |=> $stable(cnt));

  // R4
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoad |=> (cnt == $past(wrData)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((status & $past(hitVec)) == $past(hitVec)));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrMask & ~hitVec)) |=> ((status & $past(clrMask & ~hitVec)) == '0));
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busWrEn,
  input  logic [AW-1:0]     busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irq
);
  strobe_t stb;

  tmt_ctrl #(.NUM_CH(NUM_CH), .AW(AW)) i_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  tmt_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cntEn  (cntEn),
    .stb    (stb),
    .wrData (busWrData),
    .rdData (busRdData),
    .irq    (irq)
  );
endmodule

// File: tb/test_tick_match_timer.sv
`timescale 1ns/1ps
module test_tick_match_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  tick_match_timer i_tick_match_timer (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  localparam logic [2:0] A_CNT = 3'd4, A_STS = 3'd5, A_RSV = 3'd6, A_EN = 3'd7;

  task automatic expRd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busAddr = a;
    q.push_back('{1'b0, e, t});
  endtask

  task automatic expIrq(input logic [3:0] e, input string t);
    @(negedge clk);
    q.push_back('{1'b1, {28'd0, e}, t});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic wrTick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; cntEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; cntEn = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  // monitor: compares one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.isIrq ? {28'd0, irq} : busRdData;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) expRd(3'(i), 32'hFFFF_FFFF, "R1 match reset");
    expRd(A_CNT, 32'd0, "R1 counter reset");
    expRd(A_STS, 32'd0, "R1 status reset");
    expRd(A_EN, 32'd0, "R1 enable reset");
    expIrq(4'h0, "R1 irq reset");
    // R4 load, R2 count and hold
    wr(A_CNT, 32'd100);
    expRd(A_CNT, 32'd100, "R4 counter load");
    tick(5);
    expRd(A_CNT, 32'd105, "R2 five increments");
    repeat (4) @(negedge clk);
    expRd(A_CNT, 32'd105, "R2 hold without enable");
    // R5 matches
    wr(3'd0, 32'd110);
    wr(3'd2, 32'd107);
    expRd(3'd2, 32'd107, "R11 match2 readback");
    tick(3);
    expRd(A_STS, 32'h4, "R5 channel 2 event");
    expIrq(4'h0, "R8 masked while enable zero");
    tick(3);
    expRd(A_STS, 32'h5, "R5 sticky plus channel 0");
    expRd(A_CNT, 32'd111, "R2 counter after six ticks");
    // R8 enable, R6 clear
    wr(A_EN, 32'h5);
    expIrq(4'h5, "R8 irq follows flags and enables");
    wr(A_STS, 32'h4);
    expRd(A_STS, 32'h1, "R6 clear bit 2 only");
    expIrq(4'h1, "R8 irq after clear");
    wr(A_STS, 32'h0);
    expRd(A_STS, 32'h1, "R6 zero write no effect");
    wr(A_STS, 32'h0F);
    expRd(A_STS, 32'h0, "R6 clear all");
    // R7 set wins over clear
    wr(3'd1, 32'd111);
    wrTick(A_STS, 32'h2);
    expRd(A_STS, 32'h2, "R7 set wins");
    expIrq(4'h0, "R8 channel 1 not enabled");
    // R4 load beats increment
    wrTick(A_CNT, 32'd500);
    expRd(A_CNT, 32'd500, "R4 load over increment");
    wr(A_STS, 32'h0F);
    // R9 retarget
    wr(3'd3, 32'd499);
    tick(10);
    expRd(A_STS, 32'h0, "R9 passed value no event");
    wr(3'd3, 32'd515);
    tick(10);
    expRd(A_STS, 32'h8, "R9 new target fires");
    expRd(A_CNT, 32'd520, "R2 counter after retarget");
    // R3 wrap
    wr(A_STS, 32'h0F);
    wr(3'd0, 32'd0);
    wr(A_CNT, 32'hFFFF_FFFE);
    tick(3);
    expRd(A_CNT, 32'd1, "R3 wrap through zero");
    expRd(A_STS, 32'h1, "R3 match at zero after wrap");
    expIrq(4'h1, "R3 irq at wrap match");
    // R10 reserved index
    wr(A_RSV, 32'hFFFF_FFFF);
    expRd(A_RSV, 32'h0, "R10 reserved reads zero");
    expRd(A_EN, 32'h5, "R10 enable untouched");
    expRd(A_STS, 32'h1, "R10 status untouched");
    expRd(A_CNT, 32'd1, "R10 counter untouched");
    expRd(3'd1, 32'd111, "R10 match1 untouched");
    // R8 mask all
    wr(A_EN, 32'h0);
    expIrq(4'h0, "R8 mask all");
    expRd(A_STS, 32'h1, "R8 flags kept when masked");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule